// File: doc/BRIEF.md
# Serial FIFO Trigger and Flow Control

This block holds the transmit and receive byte queues of a serial port and turns their fill levels into two status flags for the rest of the port. Both queues are first-word-fall-through FIFOs of 16 bytes. An 8-bit control word sets three things: the receive trigger code, the transmit trigger code and a modem-control enable.

The receive flag is raised once enough bytes are waiting. The byte count behind each receive code depends on whether the port runs in asynchronous or synchronous mode. The transmit flag is raised once the transmit queue has drained to its threshold. Both flags are sticky. A clear strobe only removes a flag when its condition no longer holds.

The block also produces the port's hardware flow control. It passes the CTS pin through as an effective CTS, which the transmitter uses to gate the start of a frame. It drives RTS from the receive fill level. With modem control off, both signals are held at their active level, 0. In synchronous mode the enable bit has no effect.

Top module: `sfifo_trig_ctrl`

## Requirements
- R1: While rst_ni is low, both counts, both flags, rts_no and cts_eff_no are 0, and the control word is 0.
- R2: Each FIFO holds up to 16 bytes in order. A push stores the byte and the count rises by one after the clock edge. A pop removes the head byte. *_data_o shows the oldest byte whenever the count is nonzero.
- R3: A push while the count is 16 is ignored, and so is a pop while the count is 0. In both cases the count and the stored bytes are unchanged.
- R4: In asynchronous mode (sync_mode_i=0), the receive code is ctrl bits [7:6]. Codes 0, 1, 2 and 3 set a threshold of 1, 4, 8 and 14 bytes. rx_full_o is set at the edge after rx_count_o is at or above the threshold.
- R5: In synchronous mode (sync_mode_i=1), receive codes 0, 1, 2 and 3 set a threshold of 1, 2, 8 and 14 bytes.
- R6: The transmit code is ctrl bits [5:4]. Codes 0, 1, 2 and 3 set a remaining-byte threshold of 8, 4, 2 and 0. tx_empty_o is set at the edge after tx_count_o is at or below the threshold.
- R7: Each flag stays set until its clear strobe is high at an edge while its condition does not hold. A clear while the condition holds leaves the flag at 1.
- R8: With ctrl bit 3 = 0, cts_eff_no and rts_no are 0 whatever cts_ni is.
- R9: With ctrl bit 3 = 1 in asynchronous mode, cts_eff_no follows cts_ni. rts_no is 1 when rx_count_o is 15 or more, and 0 otherwise.
- R10: In synchronous mode, ctrl bit 3 is ignored, and cts_eff_no and rts_no are 0.
- R11: The control word is loaded from ctrl_wdata_i at an edge with ctrl_we_i high. A new code affects the flags from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | 1 selects synchronous mode, 0 selects asynchronous mode |
| ctrl_we_i | input | 1 | Control word write enable |
| ctrl_wdata_i | input | 8 | Control word: [7:6] receive code, [5:4] transmit code, [3] modem enable |
| tx_push_i | input | 1 | Push tx_data_i into the transmit FIFO |
| tx_data_i | input | 8 | Byte to push into the transmit FIFO |
| tx_pop_i | input | 1 | Pop the transmit FIFO head |
| tx_data_o | output | 8 | Transmit FIFO head byte |
| tx_count_o | output | 5 | Transmit FIFO fill count |
| rx_push_i | input | 1 | Push rx_data_i into the receive FIFO |
| rx_data_i | input | 8 | Byte to push into the receive FIFO |
| rx_pop_i | input | 1 | Pop the receive FIFO head |
| rx_data_o | output | 8 | Receive FIFO head byte |
| rx_count_o | output | 5 | Receive FIFO fill count |
| rx_full_clr_i | input | 1 | Clear strobe for rx_full_o |
| tx_empty_clr_i | input | 1 | Clear strobe for tx_empty_o |
| rx_full_o | output | 1 | Receive trigger flag (sticky) |
| tx_empty_o | output | 1 | Transmit trigger flag (sticky) |
| cts_ni | input | 1 | CTS pin, active low |
| cts_eff_no | output | 1 | Effective CTS, active low |
| rts_no | output | 1 | RTS, active low |

## Verification
A corrupted pointer shows up on the data port at once, as a head byte out of order. A corrupted count shows up on the count port in the same cycle and moves rts_no with it. A wrong threshold decode, or wrong sticky logic, shows up one edge later as a flag that is set or cleared in the wrong cycle. Every comparison is made each cycle against a reference queue model, so a fault is caught no later than the cycle after it first reaches a port.

// File: rtl/sft_pkg.sv
package sft_pkg;
  typedef struct packed {
    logic [1:0] rx_code;
    logic [1:0] tx_code;
    logic       mdm_en;
    logic [2:0] rsvd;
  } ctrl_t;

  function automatic int unsigned rx_level(logic [1:0] code, logic sync_mode);
    case (code)
      2'd0:    return 1;
      2'd1:    return sync_mode ? 2 : 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int unsigned tx_level(logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 4;
      2'd2:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/sft_fifo.sv
module sft_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign push_ok = push_i && (cnt_q != CW'(DEPTH));
  assign pop_ok  = pop_i && (cnt_q != '0);

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= nxt(wptr_q);
      if (pop_ok)  rptr_q <= nxt(rptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= data_i;
  end

  assign data_o  = mem_q[rptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/sft_flag.sv
module sft_flag #(
  parameter int CW       = 5,
  parameter bit AT_LEAST = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] level_i,
  input  logic          clr_i,
  output logic          flag_o
);
  logic cond, flag_q;

  generate
    if (AT_LEAST) begin : g_ge
      assign cond = count_i >= level_i;
    end else begin : g_le
      assign cond = count_i <= level_i;
    end
  endgenerate

  // sticky: only a clear with the condition gone drops the flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= cond | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sft_modem.sv
module sft_modem #(
  parameter int CW        = 5,
  parameter int RTS_LEVEL = 15
) (
  input  logic          en_i,
  input  logic          cts_ni,
  input  logic [CW-1:0] rx_count_i,
  output logic          cts_eff_no,
  output logic          rts_no
);
  assign cts_eff_no = en_i ? cts_ni : 1'b0;
  assign rts_no     = en_i ? (rx_count_i >= CW'(RTS_LEVEL)) : 1'b0;
endmodule

// File: rtl/sfifo_trig_ctrl.sv
module sfifo_trig_ctrl
  import sft_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter int RTS_LEVEL = 15,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_mode_i,
  input  logic          ctrl_we_i,
  input  logic [7:0]    ctrl_wdata_i,
  input  logic          tx_push_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_pop_i,
  output logic [DW-1:0] tx_data_o,
  output logic [CW-1:0] tx_count_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_pop_i,
  output logic [DW-1:0] rx_data_o,
  output logic [CW-1:0] rx_count_o,
  input  logic          rx_full_clr_i,
  input  logic          tx_empty_clr_i,
  output logic          rx_full_o,
  output logic          tx_empty_o,
  input  logic          cts_ni,
  output logic          cts_eff_no,
  output logic          rts_no
);
  ctrl_t         ctrl_q;
  logic [CW-1:0] rx_lvl, tx_lvl;
  logic          mdm_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_t'(ctrl_wdata_i);
  end

  assign rx_lvl = CW'(rx_level(ctrl_q.rx_code, sync_mode_i));
  assign tx_lvl = CW'(tx_level(ctrl_q.tx_code));
  // modem control is not allowed in synchronous mode
  assign mdm_en = ctrl_q.mdm_en & ~sync_mode_i;

  sft_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i (tx_push_i), .data_i (tx_data_i), .pop_i (tx_pop_i),
    .data_o (tx_data_o), .count_o(tx_count_o)
  );

  sft_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_push_i), .data_i (rx_data_i), .pop_i (rx_pop_i),
    .data_o (rx_data_o), .count_o(rx_count_o)
  );

  sft_flag #(.CW(CW), .AT_LEAST(1'b1)) u_rx_flag (
    .clk_i, .rst_ni,
    .count_i(rx_count_o), .level_i(rx_lvl), .clr_i(rx_full_clr_i), .flag_o(rx_full_o)
  );

  sft_flag #(.CW(CW), .AT_LEAST(1'b0)) u_tx_flag (
    .clk_i, .rst_ni,
    .count_i(tx_count_o), .level_i(tx_lvl), .clr_i(tx_empty_clr_i), .flag_o(tx_empty_o)
  );

  sft_modem #(.CW(CW), .RTS_LEVEL(RTS_LEVEL)) u_modem (
    .en_i(mdm_en), .cts_ni, .rx_count_i(rx_count_o), .cts_eff_no, .rts_no
  );
endmodule

// File: rtl/sft_chk.sv
module sft_chk #(
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter int RTS_LEVEL = 15,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sync_mode_i,
  input logic          rx_push_i,
  input logic          rx_pop_i,
  input logic          tx_push_i,
  input logic [CW-1:0] tx_count_o,
  input logic [CW-1:0] rx_count_o,
  input logic          rx_full_o,
  input logic          tx_empty_o,
  input logic          tx_empty_clr_i,
  input logic          rx_full_clr_i,
  input logic          cts_eff_no,
  input logic          rts_no
);
  // R3
  rx_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count_o <= CW'(DEPTH));
  // R3
  tx_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_count_o <= CW'(DEPTH));
  // R2
  rx_push_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && !rx_pop_i && rx_count_o < CW'(DEPTH)) |=> rx_count_o == $past(rx_count_o) + 1'b1);
  // R2
  tx_no_push_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_push_i |=> tx_count_o <= $past(tx_count_o));
  // R4
  rx_flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_o) |-> $past(rx_count_o) != '0);
  // R7
  tx_flag_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_empty_o) |-> $past(tx_empty_clr_i));
  // R7
  rx_flag_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_full_o) |-> $past(rx_full_clr_i));
  // R9
  rts_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_no |-> rx_count_o >= CW'(RTS_LEVEL));
  // R10
  sync_pins_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_mode_i |-> (!rts_no && !cts_eff_no));
endmodule

bind sfifo_trig_ctrl sft_chk #(.DW(DW), .DEPTH(DEPTH), .RTS_LEVEL(RTS_LEVEL)) u_chk (.*);

// File: tb/sfifo_trig_ctrl_tb.sv
module sfifo_trig_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       mode = 0, we = 0, tp = 0, tpo = 0, rp = 0, rpo = 0, rclr = 0, tclr = 0, cts = 1;
  logic [7:0] wd = 0, td = 0, rd = 0;
  logic [7:0] tdo, rdo;
  logic [4:0] tcnt, rcnt;
  logic       rxf, txe, ctse, rts;

  sfifo_trig_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_mode_i(mode), .ctrl_we_i(we), .ctrl_wdata_i(wd),
    .tx_push_i(tp), .tx_data_i(td), .tx_pop_i(tpo), .tx_data_o(tdo), .tx_count_o(tcnt),
    .rx_push_i(rp), .rx_data_i(rd), .rx_pop_i(rpo), .rx_data_o(rdo), .rx_count_o(rcnt),
    .rx_full_clr_i(rclr), .tx_empty_clr_i(tclr), .rx_full_o(rxf), .tx_empty_o(txe),
    .cts_ni(cts), .cts_eff_no(ctse), .rts_no(rts)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_tx[$], m_rx[$];
  logic [7:0] m_ctrl = 0;
  logic m_rxf = 0, m_txe = 0;

  function automatic int rx_th(logic [1:0] c, logic s);
    int t[4] = '{1, 4, 8, 14};
    if (s && c == 2'd1) return 2;
    return t[c];
  endfunction

  function automatic int tx_th(logic [1:0] c);
    int t[4] = '{8, 4, 2, 0};
    return t[c];
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic compare();
    logic en;
    en = m_ctrl[3] & ~mode;
    chk("R2 tx count", tcnt, m_tx.size());
    chk("R2 rx count", rcnt, m_rx.size());
    if (m_tx.size() > 0) chk("R2 tx head", tdo, m_tx[0]);
    if (m_rx.size() > 0) chk("R2 rx head", rdo, m_rx[0]);
    chk(mode ? "R5 R7 rx flag" : "R4 R7 rx flag", rxf, m_rxf);
    chk("R6 R7 tx flag", txe, m_txe);
    chk(en ? "R9 rts" : (mode ? "R10 rts" : "R8 rts"), rts, en ? int'(m_rx.size() >= 15) : 0);
    chk(en ? "R9 cts" : (mode ? "R10 cts" : "R8 cts"), ctse, en ? int'(cts) : 0);
  endtask

  // one clock: model follows the edge, outputs compared at the next falling edge
  task automatic step();
    logic rc, tc;
    @(posedge clk);
    rc = m_rx.size() >= rx_th(m_ctrl[7:6], mode);
    tc = m_tx.size() <= tx_th(m_ctrl[5:4]);
    m_rxf = rc | (m_rxf & ~rclr);
    m_txe = tc | (m_txe & ~tclr);
    begin
      int ts = m_tx.size(), rs = m_rx.size();
      if (tpo && ts > 0) void'(m_tx.pop_front());
      if (tp && ts < 16) m_tx.push_back(td);
      if (rpo && rs > 0) void'(m_rx.pop_front());
      if (rp && rs < 16) m_rx.push_back(rd);
    end
    if (we) m_ctrl = wd;
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    we = 0; tp = 0; tpo = 0; rp = 0; rpo = 0; rclr = 0; tclr = 0;
  endtask

  initial begin
    #500us;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tx count", tcnt, 0);
    chk("R1 rx count", rcnt, 0);
    chk("R1 rx flag", rxf, 0);
    chk("R1 tx flag", txe, 0);
    chk("R1 rts", rts, 0);
    chk("R1 cts", ctse, 0);
    rst_n = 1'b1;
    step();

    // R11 R9: enable modem, rx code 3 (14), tx code 3 (0), async
    we = 1; wd = 8'b1111_1000; step(); idle();
    cts = 1; step(); cts = 0; step(); cts = 1;
    // R3: fill rx past full, then drain past empty
    for (int i = 0; i < 18; i++) begin rp = 1; rd = 8'(8'h30 + i); step(); end
    idle(); rclr = 1; step(); rclr = 0;
    for (int i = 0; i < 18; i++) begin rpo = 1; step(); end
    idle(); rclr = 1; step(); idle(); step();
    // R3: tx full, push+pop while full
    for (int i = 0; i < 17; i++) begin tp = 1; td = 8'(8'h80 + i); step(); end
    tp = 1; tpo = 1; td = 8'hEE; step(); idle();
    for (int i = 0; i < 17; i++) begin tpo = 1; tclr = 1; step(); end
    idle(); step();
    // R5 R10: sync mode, rx code 1 (2), enable bit set but ignored
    mode = 1; we = 1; wd = 8'b0100_1000; step(); idle();
    for (int i = 0; i < 3; i++) begin rp = 1; rd = 8'(i); step(); end
    idle(); rclr = 1; step();
    rclr = 0; rpo = 1; step(); step(); idle(); rclr = 1; step(); idle(); step();
    mode = 0; step();

    // random phase over all codes, modes and strobes
    for (int i = 0; i < 6000; i++) begin
      int bias;
      bias = (i / 400) % 3;
      we   = ($urandom % 40) == 0;
      wd   = 8'($urandom);
      if (($urandom % 150) == 0) mode = ~mode;
      cts  = 1'($urandom);
      tp   = ($urandom % 4) < (bias == 0 ? 3 : 1);
      tpo  = ($urandom % 4) < (bias == 1 ? 3 : 1);
      rp   = ($urandom % 4) < (bias == 2 ? 3 : 2);
      rpo  = ($urandom % 4) < (bias == 0 ? 3 : 1);
      td   = 8'($urandom);
      rd   = 8'($urandom);
      rclr = ($urandom % 3) == 0;
      tclr = ($urandom % 3) == 0;
      step();
    end
    idle();
    step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule